// File: doc/BRIEF.md
# Sample Bit-Plane Streaming Serializer

This block turns the output of a low-resolution sample quantizer into one serial data line. Up to four one-bit lines are captured on every sample-enable cycle: in-phase sign, in-phase magnitude, quadrature sign and quadrature magnitude. Each line fills a 16-sample holding register. When a period of 16 samples closes, the holding registers move into shift registers. During the next period the chosen bit lines go out one after another, each as a 16-bit slice. The design runs entirely in the serial clock domain. The sample rate is marked by a one-cycle enable, and the serial clock must run at least four times faster than that enable.

A per-slice sync pulse marks the first bit of every slice. A separate time pulse repeats every N accepted samples. An optional frame stamp carrying a running period number can be placed ahead of the data slices. Streaming is switched on and off by rising edges on command inputs. A third command edge clears every counter at once.

Top module: `sbp_serializer`

## Requirements
- R1: On each clock with `smp_en` high, bit p of `smp_bits` is captured for line p. The clock edge that accepts the 16th sample of a period moves the period into the shift registers. The first serial bit appears in the cycle after that edge. Within a slice, samples go out in the order they were taken.
- R2: `plane_sel` chooses the lines to send: 0 = line 0 only; 1 = lines 0 and 1; 2 = lines 0 and 2; 3 = lines 0, 1, 2 and 3. Slices go out in ascending line order, back to back.
- R3: Once the last slice of a period has been sent, `data_out` and `data_sync` stay low until the next period transfer. `plane_sel` and `stamp_en` are sampled only at the transfer edge.
- R4: While `dsync_en` is high, `data_sync` is high exactly in the cycle that carries the first bit of each slice, stamp slices included. While `dsync_en` is low, `data_sync` stays low.
- R5: If `stamp_en` is high at a transfer, a 32-bit word goes out first, MSB first, as two slices. The word holds 4 zero bits above a 28-bit period number. That number counts transfers since reset or clear, starting at 0. The data slices follow it without loss.
- R6: A rising edge of `start_cmd` turns streaming on and a rising edge of `stop_cmd` turns it off; if both rise together, stop wins. A command held high does not act again. While streaming is off, `data_out` and `data_sync` are low, but capture and period counting go on.
- R7: `time_sync` is a one-cycle pulse in the cycle after every Nth accepted sample, counted from reset or clear. N is `tsync_len` clamped to the range 128 to 16384.
- R8: With `tsync_always` high, `time_sync` pulses whether or not streaming is on. With it low, a pulse is issued only if streaming was on at the edge that accepted the Nth sample.
- R9: A rising edge of `clr_cmd` clears the sample, period and time-pulse counters and abandons the current transmission on that edge. A sample offered on that edge is discarded, and the streaming state is kept.
- R10: With `smp_en` high every 4th clock and all four lines selected, the 64 bits of each period go out with no gap between periods.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Serial clock |
| rst | input | 1 | Synchronous active-high reset |
| smp_en | input | 1 | One-cycle sample strobe |
| smp_bits | input | 4 | Quantizer bit lines 0..3 |
| plane_sel | input | 2 | Line selection code |
| stamp_en | input | 1 | Insert period stamp |
| dsync_en | input | 1 | Enable per-slice sync |
| tsync_always | input | 1 | Time pulse also while stopped |
| tsync_len | input | 15 | Time pulse interval in samples |
| start_cmd | input | 1 | Streaming start, rising edge |
| stop_cmd | input | 1 | Streaming stop, rising edge |
| clr_cmd | input | 1 | Counter clear, rising edge |
| data_out | output | 1 | Serial data |
| data_sync | output | 1 | Slice start marker |
| time_sync | output | 1 | Periodic time pulse |

## Verification
Random sample bits are driven at the minimum 4x ratio with all lines selected. This shows whether periods join seamlessly or lose bits at the hand-over. Each selection code is then run at slower ratios with idle gaps, which separates wrong line order from missing zero fill. Stamped periods at 6x and 8x show whether displaced data is delayed or dropped. Held-high commands, a clear that lands on a sample edge, and out-of-range time intervals (below 128 and above 16384) probe the edge detection, the discarded sample and the clamping.

// File: rtl/sbp_pkg.sv
package sbp_pkg;
    localparam int SLICE_LEN  = 16;
    localparam int NUM_LINES  = 4;
    localparam int FRAME_W    = 28;
    localparam int TS_MIN     = 128;
    localparam int TS_MAX     = 16384;
    localparam int TS_CW      = $clog2(TS_MAX);
    localparam int TS_LW      = TS_CW + 1;

    typedef enum logic [1:0] {
        SEL_L0   = 2'd0,
        SEL_L01  = 2'd1,
        SEL_L02  = 2'd2,
        SEL_LALL = 2'd3
    } line_sel_e;

    typedef struct packed {
        logic clr;
        logic stop;
        logic start;
    } cmd_t;

    // number of 16-bit slots in one period
    function automatic logic [2:0] slot_total(line_sel_e sel, logic stamp);
        logic [2:0] n;
        case (sel)
            SEL_L0:  n = 3'd1;
            SEL_L01: n = 3'd2;
            SEL_L02: n = 3'd2;
            default: n = 3'd4;
        endcase
        return stamp ? n + 3'd2 : n;
    endfunction

    // which bit line feeds data slot j
    function automatic logic [1:0] line_of_slot(line_sel_e sel, logic [1:0] j);
        case (sel)
            SEL_L0:  return 2'd0;
            SEL_L02: return (j == 2'd0) ? 2'd0 : 2'd2;
            default: return j;
        endcase
    endfunction

    // terminal count of the time pulse counter, interval clamped
    function automatic logic [TS_CW-1:0] ts_last(logic [TS_LW-1:0] len);
        if (len < TS_LW'(TS_MIN)) return TS_CW'(TS_MIN - 1);
        if (len > TS_LW'(TS_MAX)) return TS_CW'(TS_MAX - 1);
        return TS_CW'(len - 1'b1);
    endfunction
endpackage

// File: rtl/sbp_cmd_edge.sv
module sbp_cmd_edge #(
    parameter int W = 3
) (
    input  logic         clk,
    input  logic [W-1:0] cmd,
    output logic [W-1:0] rise
);
    logic [W-1:0] prev;

    always_ff @(posedge clk) prev <= cmd;

    for (genvar i = 0; i < W; i++) begin : g_edge
        assign rise[i] = cmd[i] & ~prev[i];
    end
endmodule

// File: rtl/sbp_capture.sv
module sbp_capture #(
    parameter int SLICE = 16,
    parameter int LINES = 4
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        clr,
    input  logic                        smp_en,
    input  logic [LINES-1:0]            bits_in,
    output logic                        boundary,
    output logic [LINES-1:0][SLICE-1:0] hold_next
);
    localparam int CW = $clog2(SLICE);

    logic [CW-1:0]                 cnt;
    logic [LINES-1:0][SLICE-1:0]   hold;

    for (genvar p = 0; p < LINES; p++) begin : g_line
        assign hold_next[p] = {bits_in[p], hold[p][SLICE-1:1]};
    end

    assign boundary = smp_en & ~clr & (cnt == CW'(SLICE - 1));

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            cnt  <= '0;
            hold <= '0;
        end else if (smp_en) begin
            cnt  <= cnt + 1'b1;
            hold <= hold_next;
        end
    end
endmodule

// File: rtl/sbp_tx.sv
module sbp_tx
    import sbp_pkg::*;
#(
    parameter int SLICE   = 16,
    parameter int LINES   = 4,
    parameter int FRAME_B = 28
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        clr,
    input  logic                        boundary,
    input  logic [LINES-1:0][SLICE-1:0] hold_next,
    input  line_sel_e                   sel,
    input  logic                        stamp_en,
    output logic                        busy,
    output logic                        cur_bit,
    output logic                        slice_start
);
    localparam int CW      = $clog2(SLICE);
    localparam int STAMP_W = 2 * SLICE;

    logic [LINES-1:0][SLICE-1:0] sh;
    logic [STAMP_W-1:0]          stamp_sh;
    logic [FRAME_B-1:0]          frame;
    logic [2:0]                  slot, nslots, dslot;
    logic [CW-1:0]               pos;
    line_sel_e                   sel_q;
    logic                        stamp_q;
    logic                        in_stamp;
    logic [1:0]                  line;

    assign in_stamp    = stamp_q && (slot < 3'd2);
    assign dslot       = stamp_q ? slot - 3'd2 : slot;
    assign line        = line_of_slot(sel_q, dslot[1:0]);
    assign cur_bit     = in_stamp ? stamp_sh[STAMP_W-1] : sh[line][0];
    assign slice_start = busy && (pos == '0);

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            busy    <= 1'b0;
            slot    <= '0;
            pos     <= '0;
            frame   <= '0;
            nslots  <= 3'd1;
            sel_q   <= SEL_L0;
            stamp_q <= 1'b0;
        end else if (boundary) begin
            sh       <= hold_next;
            stamp_sh <= STAMP_W'(frame);
            frame    <= frame + 1'b1;
            sel_q    <= sel;
            stamp_q  <= stamp_en;
            nslots   <= slot_total(sel, stamp_en);
            slot     <= '0;
            pos      <= '0;
            busy     <= 1'b1;
        end else if (busy) begin
            if (in_stamp) stamp_sh <= stamp_sh << 1;
            else          sh[line] <= sh[line] >> 1;
            pos <= pos + 1'b1;
            if (pos == CW'(SLICE - 1)) begin
                if (slot == nslots - 3'd1) busy <= 1'b0;
                else                       slot <= slot + 3'd1;
            end
        end
    end
endmodule

// File: rtl/sbp_tsync.sv
module sbp_tsync
    import sbp_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             smp_en,
    input  logic [TS_LW-1:0] len,
    input  logic             gate,
    output logic             pulse
);
    logic [TS_CW-1:0] cnt;
    logic [TS_CW-1:0] last;

    assign last = ts_last(len);

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            cnt   <= '0;
            pulse <= 1'b0;
        end else begin
            pulse <= 1'b0;
            if (smp_en) begin
                if (cnt >= last) begin
                    cnt   <= '0;
                    pulse <= gate;
                end else begin
                    cnt <= cnt + 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/sbp_serializer.sv
module sbp_serializer
    import sbp_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             smp_en,
    input  logic [3:0]       smp_bits,
    input  logic [1:0]       plane_sel,
    input  logic             stamp_en,
    input  logic             dsync_en,
    input  logic             tsync_always,
    input  logic [14:0]      tsync_len,
    input  logic             start_cmd,
    input  logic             stop_cmd,
    input  logic             clr_cmd,
    output logic             data_out,
    output logic             data_sync,
    output logic             time_sync
);
    cmd_t                                cmd_rise;
    logic                                streaming;
    logic                                cap_boundary;
    logic [NUM_LINES-1:0][SLICE_LEN-1:0] cap_hold;
    logic                                tx_busy, tx_bit, tx_first;

    sbp_cmd_edge #(.W(3)) u_edge (
        .clk  (clk),
        .cmd  ({clr_cmd, stop_cmd, start_cmd}),
        .rise (cmd_rise)
    );

    always_ff @(posedge clk) begin
        if (rst)                 streaming <= 1'b0;
        else if (cmd_rise.stop)  streaming <= 1'b0;
        else if (cmd_rise.start) streaming <= 1'b1;
    end

    sbp_capture #(.SLICE(SLICE_LEN), .LINES(NUM_LINES)) u_cap (
        .clk       (clk),
        .rst       (rst),
        .clr       (cmd_rise.clr),
        .smp_en    (smp_en),
        .bits_in   (smp_bits),
        .boundary  (cap_boundary),
        .hold_next (cap_hold)
    );

    sbp_tx #(.SLICE(SLICE_LEN), .LINES(NUM_LINES), .FRAME_B(FRAME_W)) u_tx (
        .clk         (clk),
        .rst         (rst),
        .clr         (cmd_rise.clr),
        .boundary    (cap_boundary),
        .hold_next   (cap_hold),
        .sel         (line_sel_e'(plane_sel)),
        .stamp_en    (stamp_en),
        .busy        (tx_busy),
        .cur_bit     (tx_bit),
        .slice_start (tx_first)
    );

    sbp_tsync u_ts (
        .clk    (clk),
        .rst    (rst),
        .clr    (cmd_rise.clr),
        .smp_en (smp_en),
        .len    (tsync_len),
        .gate   (tsync_always | streaming),
        .pulse  (time_sync)
    );

    assign data_out  = streaming & tx_busy & tx_bit;
    assign data_sync = streaming & dsync_en & tx_first;
endmodule

// File: rtl/sbp_serializer_chk.sv
module sbp_serializer_chk (
    input logic clk,
    input logic rst,
    input logic smp_en,
    input logic stop_cmd,
    input logic clr_cmd,
    input logic data_out,
    input logic data_sync,
    input logic time_sync,
    input logic boundary,
    input logic tx_busy
);
    // R6: a stop edge silences the serial outputs in the next cycle
    a_r6_stop_silences: assert property (@(posedge clk) disable iff (rst)
        $rose(stop_cmd) |=> (!data_out && !data_sync));

    // R9: a clear edge abandons transmission and the pending time pulse
    a_r9_clear_quiets: assert property (@(posedge clk) disable iff (rst)
        $rose(clr_cmd) |=> (!data_out && !data_sync && !time_sync));

    // R7: the time pulse lasts one cycle
    a_r7_pulse_single: assert property (@(posedge clk) disable iff (rst)
        time_sync |=> !time_sync);

    // R7: the time pulse follows an accepted sample
    a_r7_pulse_after_sample: assert property (@(posedge clk) disable iff (rst)
        time_sync |-> $past(smp_en));

    // R1: a period transfer starts the transmitter
    a_r1_load_starts_tx: assert property (@(posedge clk) disable iff (rst)
        boundary |=> tx_busy);
endmodule

bind sbp_serializer sbp_serializer_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .smp_en    (smp_en),
    .stop_cmd  (stop_cmd),
    .clr_cmd   (clr_cmd),
    .data_out  (data_out),
    .data_sync (data_sync),
    .time_sync (time_sync),
    .boundary  (cap_boundary),
    .tx_busy   (tx_busy)
);

// File: tb/sim_sbp_serializer.sv
`timescale 1ns/1ps
module sim_sbp_serializer;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        smp_en = 1'b0;
    logic [3:0]  smp_bits = '0;
    logic [1:0]  plane_sel = '0;
    logic        stamp_en = 1'b0;
    logic        dsync_en = 1'b0;
    logic        tsync_always = 1'b0;
    logic [14:0] tsync_len = 15'd128;
    logic        start_cmd = 1'b0;
    logic        stop_cmd = 1'b0;
    logic        clr_cmd = 1'b0;
    logic        data_out, data_sync, time_sync;

    int    n_chk = 0;
    int    n_fail = 0;
    bit    done = 1'b0;
    string tag = "R6";

    always #5 clk = ~clk;

    sbp_serializer u0 (
        .clk(clk), .rst(rst), .smp_en(smp_en), .smp_bits(smp_bits),
        .plane_sel(plane_sel), .stamp_en(stamp_en), .dsync_en(dsync_en),
        .tsync_always(tsync_always), .tsync_len(tsync_len),
        .start_cmd(start_cmd), .stop_cmd(stop_cmd), .clr_cmd(clr_cmd),
        .data_out(data_out), .data_sync(data_sync), .time_sync(time_sync)
    );

    // ---------------- reference model (from the requirements) ----------------
    bit          m_run, m_tp, p_st, p_sp, p_cl;
    int          m_cnt, m_ts;
    logic [27:0] m_frame;
    bit          m_hold [4][16];
    bit          qd [$];
    bit          qs [$];
    bit          e_d, e_s, e_t;

    function automatic int exp_last(logic [14:0] len);
        if (len < 15'd128)   return 127;
        if (len > 15'd16384) return 16383;
        return int'(len) - 1;
    endfunction

    function automatic int exp_line(logic [1:0] sel, int j);
        int lst [4];
        case (sel)
            2'd0: lst = '{0, 0, 0, 0};
            2'd1: lst = '{0, 1, 0, 0};
            2'd2: lst = '{0, 2, 0, 0};
            default: lst = '{0, 1, 2, 3};
        endcase
        return lst[j];
    endfunction

    function automatic int exp_nlines(logic [1:0] sel);
        return (sel == 2'd0) ? 1 : (sel == 2'd3) ? 4 : 2;
    endfunction

    task automatic build_period();
        logic [31:0] w;
        qd.delete(); qs.delete();
        if (stamp_en) begin
            w = {4'b0, m_frame};
            for (int i = 31; i >= 0; i--) begin
                qd.push_back(w[i]);
                qs.push_back(i == 31 || i == 15);
            end
        end
        for (int j = 0; j < exp_nlines(plane_sel); j++)
            for (int k = 0; k < 16; k++) begin
                qd.push_back(m_hold[exp_line(plane_sel, j)][k]);
                qs.push_back(k == 0);
            end
        m_frame = m_frame + 28'd1;
    endtask

    always @(posedge clk) begin
        bit st_r, sp_r, cl_r, gate, d, s;
        st_r = start_cmd & ~p_st;
        sp_r = stop_cmd & ~p_sp;
        cl_r = clr_cmd & ~p_cl;
        if (rst) begin
            m_run = 0; m_cnt = 0; m_ts = 0; m_frame = '0; m_tp = 0;
            qd.delete(); qs.delete();
            e_d = 0; e_s = 0; e_t = 0;
        end else begin
            gate = tsync_always | m_run;
            m_tp = 0;
            if (cl_r) begin
                m_cnt = 0; m_ts = 0; m_frame = '0;
                qd.delete(); qs.delete();
            end else if (smp_en) begin
                for (int p = 0; p < 4; p++) m_hold[p][m_cnt] = smp_bits[p];
                if (m_ts >= exp_last(tsync_len)) begin m_ts = 0; m_tp = gate; end
                else m_ts++;
                if (m_cnt == 15) begin build_period(); m_cnt = 0; end
                else m_cnt++;
            end
            if (sp_r) m_run = 0;
            else if (st_r) m_run = 1;
            d = 0; s = 0;
            if (qd.size() > 0) begin d = qd.pop_front(); s = qs.pop_front(); end
            e_d = m_run & d;
            e_s = m_run & s & dsync_en;
            e_t = m_tp;
        end
        p_st = start_cmd; p_sp = stop_cmd; p_cl = clr_cmd;
    end

    // ---------------- per-cycle comparison ----------------
    always @(posedge clk) begin
        #2;
        if (!rst && !done) begin
            n_chk++;
            if (data_out !== e_d) begin
                n_fail++;
                $display("FAIL %s data_out actual=%b expected=%b at %0t", tag, data_out, e_d, $time);
            end
            if (data_sync !== e_s) begin
                n_fail++;
                $display("FAIL %s/R4 data_sync actual=%b expected=%b at %0t", tag, data_sync, e_s, $time);
            end
            if (time_sync !== e_t) begin
                n_fail++;
                $display("FAIL %s/R7 time_sync actual=%b expected=%b at %0t", tag, time_sync, e_t, $time);
            end
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic send(int n, int r);
        for (int i = 0; i < n; i++) begin
            smp_bits = 4'($urandom);
            smp_en   = 1'b1;
            @(negedge clk);
            smp_en = 1'b0;
            repeat (r - 1) @(negedge clk);
        end
    endtask

    task automatic do_start();
        start_cmd = 1'b1; @(negedge clk); start_cmd = 1'b0;
    endtask

    task automatic do_stop();
        stop_cmd = 1'b1; @(negedge clk); stop_cmd = 1'b0;
    endtask

    task automatic do_clr();
        clr_cmd = 1'b1; @(negedge clk); clr_cmd = 1'b0;
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_fail++;
            $display("FAIL watchdog (all requirements) actual=running expected=finished");
            summary();
        end
    end

    initial begin
        void'($urandom(32'h51CE));
        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R6: reset state, streaming off
        n_chk++;
        if (data_out !== 1'b0 || data_sync !== 1'b0 || time_sync !== 1'b0) begin
            n_fail++;
            $display("FAIL R6 reset outputs actual=%b%b%b expected=000", data_out, data_sync, time_sync);
        end

        // R10: minimum ratio, all lines, back to back
        tag = "R10"; plane_sel = 2'd3; dsync_en = 1'b1;
        do_start();
        send(64, 4);

        // R2: each selection code
        tag = "R2";
        for (int s = 0; s < 3; s++) begin
            plane_sel = 2'(s);
            send(32, 5);
        end

        // R3: long zero fill, select changed mid-period
        tag = "R3"; plane_sel = 2'd0;
        send(8, 7);
        plane_sel = 2'd3;
        send(24, 7);

        // R5: stamped periods
        tag = "R5"; stamp_en = 1'b1; plane_sel = 2'd1;
        send(48, 8);
        plane_sel = 2'd3;
        send(48, 6);
        stamp_en = 1'b0;

        // R4: sync disabled
        tag = "R4"; dsync_en = 1'b0;
        send(32, 5);
        dsync_en = 1'b1;

        // R6: held commands, stop wins
        tag = "R6";
        do_stop();
        send(20, 5);
        start_cmd = 1'b1;
        send(16, 5);
        do_stop();
        send(32, 5);
        start_cmd = 1'b0;
        start_cmd = 1'b1; stop_cmd = 1'b1;
        @(negedge clk);
        start_cmd = 1'b0; stop_cmd = 1'b0;
        send(20, 5);
        do_start();
        send(20, 5);

        // R8: gating of the time pulse
        tag = "R8"; tsync_len = 15'd128; tsync_always = 1'b0;
        do_stop(); do_clr();
        send(300, 4);
        tsync_always = 1'b1;
        send(300, 4);

        // R7: interval clamping
        tag = "R7"; tsync_len = 15'd5; do_clr();
        send(300, 2);
        tsync_len = 15'd20000; do_clr();
        send(16500, 1);
        tsync_len = 15'd200; do_clr();
        send(450, 1);

        // R9: clear mid-period and on a sample edge
        tag = "R9"; tsync_len = 15'd128; do_start();
        send(8, 5);
        do_clr();
        send(20, 5);
        smp_bits = 4'hF; smp_en = 1'b1; clr_cmd = 1'b1;
        @(negedge clk);
        smp_en = 1'b0; clr_cmd = 1'b0;
        send(40, 5);

        // R1: random configurations
        tag = "R1";
        for (int it = 0; it < 40; it++) begin
            plane_sel    = 2'($urandom);
            stamp_en     = 1'($urandom);
            dsync_en     = 1'($urandom);
            tsync_always = 1'($urandom);
            if ($urandom_range(0, 5) == 0) do_stop();
            else if ($urandom_range(0, 3) == 0) do_start();
            send(16, $urandom_range(6, 9));
        end
        repeat (80) @(negedge clk);

        done = 1'b1;
        summary();
    end
endmodule